// File: doc/BRIEF.md
# Timed Six-Phase Test Sequencer

This block steps a test procedure through six phases in a fixed order. Only elapsed time moves it from one phase to the next; there is no handshake between phases and no input other than clock and reset. In order, the phases are: preparation, run, halt, result query, result display and wrap-up. The block divides the system clock down to a periodic tick, and a per-phase parameter sets how many ticks each phase lasts. It reports the current phase as a 3-bit code. A one-clock strobe marks every phase change, and a second strobe marks the end of each full cycle. After wrap-up the sequence starts again at preparation without any outside action.

With the default settings the clock is 50 MHz and the tick divisor is 25,000,000, which gives a 0.5 s tick. Every phase lasts 20 ticks, so a full pass takes 60 s. That is inside the 90 s (180-tick) budget. Elaboration stops with an error in three cases: the dwell times add up to more than the budget, a dwell is zero, or a dwell does not fit its counter. A small divisor can be used so that the exact length of each phase can be checked in a short run.

Top module: `phase_sequencer`

## Requirements
- R1: Phase codes follow the order 0 (preparation), 1 (run), 2 (halt), 3 (query), 4 (display), 5 (wrap-up), and 5 is followed by 0. The code changes only on a cycle where `phaseChange` is high.
- R2: Each phase that follows a transition lasts exactly PHASE_DWELL[code] × TICK_DIV clocks. The first phase after reset release lasts one clock longer, because the first tick is registered.
- R3: `phaseChange` is high for exactly one clock on every transition, including the wrap from 5 to 0, and is low at all other times.
- R4: `cycleDone` is high for exactly one clock, in the same cycle as the 5→0 transition, and at no other time.
- R5: While `rstN` is low, and without waiting for a clock edge, the outputs show phase 0 with both strobes low. After release, timing starts again from zero.
- R6: `phaseCode` never shows 6 or 7. If the state register ever holds such a value, it returns to 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| phaseCode | output | 3 | Current phase, binary 0..5 |
| phaseChange | output | 1 | One-clock strobe on each phase transition |
| cycleDone | output | 1 | One-clock strobe when leaving the wrap-up phase |

## Verification
Assertions check the following on every cycle. The code stays in the range 0..5. A transition always moves to the successor code and never anywhere else. Each strobe lasts only one cycle. The cycle-done strobe appears only together with a change out of phase 5. The tick never arrives on two consecutive clocks, and the dwell counter never passes the limit for the current phase. The exact length of each phase and the extra clock in the first phase after reset can only be shown by the bench's scenarios. The same holds for the restart after a reset in the middle of a run, and for a wrap that continues across several full passes. The bench shows these with a behavioural clock-by-clock model run over several cycles that use dwell times of different lengths.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int NUM_PHASES = 6;

  typedef enum logic [2:0] {
    PH_PREP  = 3'd0,
    PH_RUN   = 3'd1,
    PH_HALT  = 3'd2,
    PH_QUERY = 3'd3,
    PH_SHOW  = 3'd4,
    PH_END   = 3'd5
  } phase_e;

  typedef int unsigned dwell_tbl_t [NUM_PHASES];

  // Strobes and state handed from the phase controller to the timebase
  typedef struct packed {
    phase_e phase;
    logic   advance;
  } ctrl_strobe_t;

  function automatic phase_e nextPhase(phase_e p);
    return (p == PH_END) ? PH_PREP : phase_e'(p + 3'd1);
  endfunction

  function automatic int unsigned dwellSum(dwell_tbl_t t);
    int unsigned s = 0;
    for (int i = 0; i < NUM_PHASES; i++) s += t[i];
    return s;
  endfunction

endpackage

// File: rtl/seq_timebase.sv
module seq_timebase
  import seq_pkg::*;
#(
  parameter int unsigned TICK_DIV    = 25_000_000,
  parameter int unsigned DWELL_W     = 8,
  parameter dwell_tbl_t  PHASE_DWELL = '{20, 20, 20, 20, 20, 20}
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_strobe_t ctrl,
  output logic         tick,
  output logic         expire
);

  localparam int unsigned DIV_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0]   divCnt;
  logic               tickQ;
  logic [DWELL_W-1:0] dwellCnt;
  logic [DWELL_W-1:0] dwellLast [NUM_PHASES];
  logic [DWELL_W-1:0] curLast;

  // Clock divider: free running, wraps at TICK_DIV
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      tickQ  <= 1'b0;
    end else begin
      divCnt <= (divCnt == DIV_LAST) ? '0 : divCnt + 1'b1;
      tickQ  <= (divCnt == DIV_LAST);
    end
  end

  // Per-phase terminal values of the dwell counter
  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_last
    assign dwellLast[g] = DWELL_W'(PHASE_DWELL[g] - 1);
  end

  always_comb begin
    curLast = '0;
    for (int i = 0; i < NUM_PHASES; i++)
      if (ctrl.phase == phase_e'(i)) curLast = dwellLast[i];
  end

  assign tick   = tickQ;
  assign expire = tickQ && (dwellCnt == curLast);

  // Dwell counter: cleared on entry to each phase, advances on ticks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             dwellCnt <= '0;
    else if (ctrl.advance) dwellCnt <= '0;
    else if (tickQ)        dwellCnt <= dwellCnt + 1'b1;
  end

  // R2: ticks are isolated single-clock pulses
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    tickQ |=> !tickQ);

  // R2: the counter never runs past the limit of the current phase
  p_dwell_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.phase <= PH_END) |-> (dwellCnt <= curLast));

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import seq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         expire,
  output ctrl_strobe_t ctrl,
  output logic         phaseChange,
  output logic         cycleDone
);

  phase_e phaseQ;
  logic   legal;

  assign legal        = (phaseQ <= PH_END);
  assign ctrl.phase   = phaseQ;
  assign ctrl.advance = legal && expire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ      <= PH_PREP;
      phaseChange <= 1'b0;
      cycleDone   <= 1'b0;
    end else begin
      phaseChange <= 1'b0;
      cycleDone   <= 1'b0;
      if (!legal) begin
        phaseQ <= PH_PREP;              // R6 recovery of codes 6 and 7
      end else if (expire) begin
        phaseQ      <= nextPhase(phaseQ);
        phaseChange <= 1'b1;
        cycleDone   <= (phaseQ == PH_END);
      end
    end
  end

  p_legal_code_r6: assert property (@(posedge clk) disable iff (!rstN)
    phaseQ <= PH_END);

  p_order_r1: assert property (@(posedge clk) disable iff (!rstN)
    phaseChange |-> (phaseQ == (($past(phaseQ) == PH_END) ? PH_PREP
                                 : phase_e'($past(phaseQ) + 3'd1))));

  p_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !phaseChange |-> $stable(phaseQ));

  p_one_clock_r3: assert property (@(posedge clk) disable iff (!rstN)
    phaseChange |=> !phaseChange);

  p_done_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |-> (phaseChange && phaseQ == PH_PREP));

  p_done_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |=> !cycleDone);

endmodule

// File: rtl/phase_sequencer.sv
module phase_sequencer
  import seq_pkg::*;
#(
  parameter int unsigned TICK_DIV     = 25_000_000,
  parameter int unsigned DWELL_W      = 8,
  parameter dwell_tbl_t  PHASE_DWELL  = '{20, 20, 20, 20, 20, 20},
  parameter int unsigned BUDGET_TICKS = 180
) (
  input  logic       clk,
  input  logic       rstN,
  output logic [2:0] phaseCode,
  output logic       phaseChange,
  output logic       cycleDone
);

  if (dwellSum(PHASE_DWELL) > BUDGET_TICKS) begin : g_budget_chk
    $error("dwell times exceed the cycle budget");
  end
  if (TICK_DIV < 2) begin : g_div_chk
    $error("tick divisor must be at least 2");
  end
  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_dwell_chk
    if (PHASE_DWELL[g] == 0 || PHASE_DWELL[g] > (1 << DWELL_W)) begin : g_bad
      $error("dwell value out of range");
    end
  end

  ctrl_strobe_t ctrl;
  logic         tick;
  logic         expire;

  seq_timebase #(
    .TICK_DIV   (TICK_DIV),
    .DWELL_W    (DWELL_W),
    .PHASE_DWELL(PHASE_DWELL)
  ) timebase_i (
    .clk   (clk),
    .rstN  (rstN),
    .ctrl  (ctrl),
    .tick  (tick),
    .expire(expire)
  );

  seq_fsm fsm_i (
    .clk        (clk),
    .rstN       (rstN),
    .expire     (expire),
    .ctrl       (ctrl),
    .phaseChange(phaseChange),
    .cycleDone  (cycleDone)
  );

  assign phaseCode = ctrl.phase;

endmodule

// File: tb/phase_sequencer_tb_top.sv
module phase_sequencer_tb_top;
  import seq_pkg::*;

  localparam int unsigned DIV = 4;
  localparam dwell_tbl_t  DW  = '{2, 3, 1, 4, 2, 3};

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] phaseCode;
  logic       phaseChange;
  logic       cycleDone;

  int  vectors = 0;
  int  fails   = 0;
  int  refPhase, refLeft;
  bit  refChg, refDone;
  bit  running = 0;
  int  runLen = 0;
  int  prevCode = -1;
  bit  seenFull3 = 0;

  always #5 clk = ~clk;

  phase_sequencer #(
    .TICK_DIV    (DIV),
    .DWELL_W     (4),
    .PHASE_DWELL (DW),
    .BUDGET_TICKS(180)
  ) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .phaseCode  (phaseCode),
    .phaseChange(phaseChange),
    .cycleDone  (cycleDone)
  );

  // Behavioural reference: clocks left in the current phase
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refPhase = 0;
      refLeft  = DW[0] * DIV + 1;
      refChg   = 0;
      refDone  = 0;
    end else begin
      refChg  = 0;
      refDone = 0;
      if (refLeft == 1) begin
        refDone  = (refPhase == 5);
        refPhase = (refPhase + 1) % 6;
        refLeft  = DW[refPhase] * DIV;
        refChg   = 1;
      end else begin
        refLeft--;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare on every falling edge while running
  always @(negedge clk) begin
    if (running && rstN) begin
      check("R1 phase code", phaseCode, refPhase);
      check("R3 phaseChange", phaseChange, refChg);
      check("R4 cycleDone", cycleDone, refDone);
      check("R6 code in range", phaseCode <= 3'd5, 1);
      if (phaseCode == 3'd3) runLen++;
      if (prevCode == 3 && phaseCode != 3'd3) begin
        check("R2 query phase length", runLen, DW[3] * DIV);
        seenFull3 = 1;
        runLen = 0;
      end
      prevCode = phaseCode;
    end
  end

  task automatic checkReset();
    check("R5 reset phase", phaseCode, 0);
    check("R5 reset change", phaseChange, 0);
    check("R5 reset done", cycleDone, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkReset();
    rstN = 1'b1;
    running = 1;
    repeat (200) @(negedge clk);
    // Mid-run asynchronous reset, taken away from any clock edge
    #2;
    running = 0;
    rstN = 1'b0;
    #1;
    checkReset();
    prevCode = -1;
    runLen = 0;
    @(negedge clk);
    checkReset();
    rstN = 1'b1;
    running = 1;
    repeat (130) @(negedge clk);
    check("R2 full query phase observed", seenFull3, 1);
    running = 0;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #20000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule